// File: doc/BRIEF.md
# Host-to-VRAM Byte Bridge

This block lets an 8-bit host processor write directly into a 16-bit video memory whose bus is shared with a display controller. The host programs a word address through two byte-wide address ports and then streams bytes through a data port; an internal byte-select toggle routes each byte to the low or the high half of the current word. Optionally the word address advances by one after every completed word, so a long image can be streamed without re-addressing.

The display controller always owns the memory bus when it needs it. A host data byte is staged in a single holding slot, and the bridge writes it to memory in the first cycle in which the controller is not using the bus. While a byte is waiting, the bridge raises a wait signal to stall the host. A control register selects address auto-increment, double buffering, a buffer swap, two upper address bits and a wide-display flag. With double buffering on, host writes are steered to the buffer that is not being shown.

Top module: `vram_host_bridge`

## Requirements
- R1: After reset the control register is all zeros, `host_wait` and `vram_we` are low, `wide_mode` is low, the word address is 0 and the byte select is 0.
- R2: Host port codes on `host_port`: 0 loads word address bits [7:0], 1 loads word address bits [15:8], 2 is a data byte, 3 loads the control register; a write to port 0 also clears the byte select to 0, a write to port 1 leaves it unchanged.
- R3: Each accepted data byte is written to the lane given by the byte select at acceptance (0 gives `vram_be` = 2'b01, 1 gives 2'b10), the byte appears on both halves of `vram_wdata`, and the byte select then toggles.
- R4: Control byte fields: bit 0 wide mode (driven on `wide_mode`), bit 1 auto-increment, bit 2 double buffering, bit 3 swap, bits [5:4] upper address bits A17:A16.
- R5: With auto-increment on, accepting a data byte while the byte select is 1 advances the word address by one, wrapping from 0xFFFF to 0; with it off the word address never changes on data writes.
- R6: `vram_addr` is {A17, A16, word address}; A16 is control bit 4; A17 is control bit 5 when double buffering is off, and the inverse of (`disp_buf` XOR swap) when it is on.
- R7: `vram_we` is never high while `slot_busy` is high; a staged byte is written in the first cycle with `slot_busy` low and exactly one cycle of `vram_we` occurs per data byte.
- R8: `host_wait` is high from the cycle after a data byte is accepted until the cycle after it is written; address, data, byte enables stay stable while it waits.
- R9: A host write of any port presented while `host_wait` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one write per cycle it is high |
| host_port | input | 2 | Host port select (see R2) |
| host_wdata | input | 8 | Host write byte |
| slot_busy | input | 1 | Display controller is using the memory bus this cycle |
| disp_buf | input | 1 | Buffer currently shown by the display path |
| vram_addr | output | 18 | Video memory word address |
| vram_wdata | output | 16 | Video memory write data |
| vram_be | output | 2 | Byte lane enables, bit 0 low byte |
| vram_we | output | 1 | Video memory write strobe |
| host_wait | output | 1 | Stall request to the host |
| wide_mode | output | 1 | Wide display mode enable from the control register |

## Verification
A wrong byte select shows on the very next committed write as a swapped `vram_be` lane, and a wrong word address or buffer steering shows as a wrong `vram_addr` on that write, so every fault in the address path surfaces within one data byte. A fault in the staging slot shows at once as a write during a busy cycle, a missing or duplicated write strobe, or `host_wait` released too early or held too long. Sweeping all control field combinations against both displayed buffers, with busy periods of varying length and an address wrap, exposes each of these within a few cycles.

// File: rtl/vhb_pkg.sv
package vhb_pkg;

    localparam int HOST_W  = 8;
    localparam int LANES   = 2;
    localparam int WORD_AW = 16;
    localparam int UPPER_W = 2;
    localparam int MEM_AW  = WORD_AW + UPPER_W;
    localparam int MEM_DW  = HOST_W * LANES;

    typedef enum logic [1:0] {
        PORT_ADDR_LO = 2'd0,
        PORT_ADDR_HI = 2'd1,
        PORT_DATA    = 2'd2,
        PORT_CTRL    = 2'd3
    } port_e;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic               swap;
        logic               dbl;
        logic               autoinc;
        logic               wide;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic [HOST_W-1:0] data;
        logic              lane;
    } stage_t;

    function automatic logic [UPPER_W-1:0] upper_bits(ctl_t c, logic shown);
        logic [UPPER_W-1:0] u;
        u = c.upper;
        if (c.dbl) u[UPPER_W-1] = ~(shown ^ c.swap);
        return u;
    endfunction

endpackage

// File: rtl/vhb_regs.sv
module vhb_regs
    import vhb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         port,
    input  logic [HOST_W-1:0]  wdata,
    output ctl_t               ctl,
    output logic [WORD_AW-1:0] word_addr,
    output logic               bsel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            word_addr <= '0;
            bsel      <= 1'b0;
        end else if (wr_en) begin
            case (port_e'(port))
                PORT_ADDR_LO: begin
                    word_addr[HOST_W-1:0] <= wdata;
                    bsel <= 1'b0;
                end
                PORT_ADDR_HI: word_addr[WORD_AW-1:HOST_W] <= wdata;
                PORT_DATA: begin
                    bsel <= ~bsel;
                    if (ctl.autoinc && bsel) word_addr <= word_addr + 1'b1;
                end
                default: ctl <= ctl_t'(wdata[CTL_W-1:0]);
            endcase
        end
    end

    // R2
    lo_clears_bsel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port == PORT_ADDR_LO) |=> !bsel);

    // R5
    autoinc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port == PORT_DATA && ctl.autoinc && bsel)
            |=> word_addr == $past(word_addr) + 1'b1);

    // R5
    no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port == PORT_DATA && !ctl.autoinc) |=> $stable(word_addr));

endmodule

// File: rtl/vhb_stage.sv
module vhb_stage
    import vhb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  stage_t            cap,
    input  logic              slot_busy,
    output logic              pending,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [MEM_DW-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be
);

    stage_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= '0;
        end else if (capture && !pending) begin
            pending <= 1'b1;
            held    <= cap;
        end else if (pending && !slot_busy) begin
            pending <= 1'b0;
        end
    end

    assign mem_we   = pending && !slot_busy;
    assign mem_addr = held.addr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_wdata[g*HOST_W +: HOST_W] = held.data;
        assign mem_be[g] = (held.lane == g[0]);
    end

    // R7
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        slot_busy |-> !mem_we);

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R3
    one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $countones(mem_be) == 1);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && slot_busy) |=> (pending && $stable(mem_addr) && $stable(mem_wdata)
                                     && $stable(mem_be)));

endmodule

// File: rtl/vram_host_bridge.sv
module vram_host_bridge
    import vhb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_port,
    input  logic [7:0]        host_wdata,
    input  logic              slot_busy,
    input  logic              disp_buf,
    output logic [17:0]       vram_addr,
    output logic [15:0]       vram_wdata,
    output logic [1:0]        vram_be,
    output logic              vram_we,
    output logic              host_wait,
    output logic              wide_mode
);

    ctl_t               ctl;
    logic [WORD_AW-1:0] word_addr;
    logic               bsel;
    logic               accepted;
    logic               capture;
    stage_t             cap;

    assign accepted = host_we && !host_wait;
    assign capture  = accepted && (host_port == PORT_DATA);

    vhb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accepted),
        .port      (host_port),
        .wdata     (host_wdata),
        .ctl       (ctl),
        .word_addr (word_addr),
        .bsel      (bsel)
    );

    always_comb begin
        cap.addr = {upper_bits(ctl, disp_buf), word_addr};
        cap.data = host_wdata;
        cap.lane = bsel;
    end

    vhb_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cap       (cap),
        .slot_busy (slot_busy),
        .pending   (host_wait),
        .mem_we    (vram_we),
        .mem_addr  (vram_addr),
        .mem_wdata (vram_wdata),
        .mem_be    (vram_be)
    );

    assign wide_mode = ctl.wide;

    // R8
    wait_rise_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> host_wait);

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wait && host_we) |=> ($stable(ctl) && $stable(word_addr) && $stable(bsel)));

endmodule

// File: tb/sim_vram_host_bridge.sv
module sim_vram_host_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_we;
    logic [1:0]  host_port;
    logic [7:0]  host_wdata;
    logic        slot_busy;
    logic        disp_buf;
    logic [17:0] vram_addr;
    logic [15:0] vram_wdata;
    logic [1:0]  vram_be;
    logic        vram_we;
    logic        host_wait;
    logic        wide_mode;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [15:0] m_addr;
    logic        m_bsel;
    logic        m_auto, m_dbl, m_swap, m_wide;
    logic [1:0]  m_up;

    always #4 clk = ~clk;

    vram_host_bridge u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_port(host_port),
        .host_wdata(host_wdata), .slot_busy(slot_busy), .disp_buf(disp_buf),
        .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vram_be(vram_be),
        .vram_we(vram_we), .host_wait(host_wait), .wide_mode(wide_mode)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] p, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_port = p; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        case (p)
            2'd0: begin m_addr[7:0] = v; m_bsel = 1'b0; end
            2'd1: m_addr[15:8] = v;
            2'd3: begin
                m_wide = v[0]; m_auto = v[1]; m_dbl = v[2]; m_swap = v[3]; m_up = v[5:4];
            end
            default: ;
        endcase
    endtask

    // data byte with busy_n busy cycles after acceptance; optional dropped write
    task automatic dwrite(input logic [7:0] v, input int busy_n, input logic poke);
        logic [17:0] ea;
        logic [1:0]  ebe;
        @(negedge clk);
        slot_busy = (busy_n > 0);
        host_we = 1'b1; host_port = 2'd2; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        ea[15:0] = m_addr;
        ea[16]   = m_up[0];
        ea[17]   = m_dbl ? ~(disp_buf ^ m_swap) : m_up[1];
        ebe      = m_bsel ? 2'b10 : 2'b01;
        chk(host_wait == 1'b1, "R8 wait after accept", {31'd0, host_wait}, 1);
        for (int i = 0; i < busy_n; i++) begin
            chk(vram_we == 1'b0, "R7 no write while busy", {31'd0, vram_we}, 0);
            chk(host_wait == 1'b1, "R8 wait held", {31'd0, host_wait}, 1);
            if (poke && i == 0) begin
                host_we = 1'b1; host_port = 2'd0; host_wdata = 8'hA5;
                @(negedge clk);
                host_we = 1'b1; host_port = 2'd3; host_wdata = 8'h3F;
                @(negedge clk);
                host_we = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        slot_busy = 1'b0;
        #1;
        chk(vram_we == 1'b1, "R7 write in free slot", {31'd0, vram_we}, 1);
        chk(vram_addr == ea, "R6 address", {14'd0, vram_addr}, {14'd0, ea});
        chk(vram_be == ebe, "R3 lane", {30'd0, vram_be}, {30'd0, ebe});
        chk(vram_wdata == {v, v}, "R3 data", {16'd0, vram_wdata}, {16'd0, v, v});
        @(negedge clk);
        chk(host_wait == 1'b0, "R8 wait release", {31'd0, host_wait}, 0);
        chk(vram_we == 1'b0, "R7 single strobe", {31'd0, vram_we}, 0);
        if (m_auto && m_bsel) m_addr = m_addr + 16'd1;
        m_bsel = ~m_bsel;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        host_we = 0; host_port = 0; host_wdata = 0; slot_busy = 0; disp_buf = 0;
        m_addr = 0; m_bsel = 0; m_auto = 0; m_dbl = 0; m_swap = 0; m_wide = 0; m_up = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(host_wait == 1'b0, "R1 wait", {31'd0, host_wait}, 0);
        chk(vram_we == 1'b0, "R1 we", {31'd0, vram_we}, 0);
        chk(wide_mode == 1'b0, "R1 wide", {31'd0, wide_mode}, 0);
        // R1: first data byte lands at address 0, lane 0
        dwrite(8'h11, 0, 1'b0);
        dwrite(8'h22, 1, 1'b0);

        // R4 R5 R6: sweep all control fields and both displayed buffers
        for (int cfg = 0; cfg < 64; cfg++) begin
            logic [7:0] cb;
            cb = {2'b00, cfg[5:4], cfg[3], cfg[2], cfg[1], cfg[3] ^ cfg[4]};
            disp_buf = cfg[0];
            put(2'd3, cb);
            chk(wide_mode == m_wide, "R4 wide bit", {31'd0, wide_mode}, {31'd0, m_wide});
            put(2'd1, 8'(cfg * 3));
            put(2'd0, 8'(cfg * 7 + 1));
            dwrite(8'(cfg), cfg % 3, 1'b0);
            // R2: high-byte write keeps the byte select
            put(2'd1, 8'(cfg * 5));
            dwrite(8'(cfg + 64), (cfg + 1) % 3, 1'b0);
            dwrite(8'(cfg + 128), 0, 1'b0);
        end

        // R5 wrap from 0xFFFF
        disp_buf = 1'b0;
        put(2'd3, 8'h02);
        put(2'd1, 8'hFF);
        put(2'd0, 8'hFF);
        dwrite(8'hA1, 0, 1'b0);
        dwrite(8'hA2, 2, 1'b0);
        dwrite(8'hA3, 0, 1'b0);

        // R9: writes to address and control while waiting are dropped
        put(2'd1, 8'h12);
        put(2'd0, 8'h34);
        dwrite(8'hB1, 3, 1'b1);
        dwrite(8'hB2, 3, 1'b1);
        dwrite(8'hB3, 0, 1'b0);
        chk(wide_mode == 1'b0, "R9 control unchanged", {31'd0, wide_mode}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule